// File: doc/BRIEF.md
# Multi-Focus Transducer Phase Calculator

This block turns a short list of focal points into a drive setting for each element of an ultrasound transducer array. A caller presents one transducer position at a time. For that position the block walks every active focus in turn. For each focus it forms the squared distance to the transducer, takes an exact integer square root, scales it into a phase index with a division by the sound-speed value, and looks up sine and cosine values.

When all foci are done, the block averages the sine and cosine sums and resolves them into one 8-bit phase. The phase is the angle whose table sine and cosine best match the averages. The result goes out with a one-cycle valid strobe, together with an 8-bit intensity taken from the first focus.

The square root and the division are bit-serial and shared by all foci. The sine table is computed at elaboration. The angle is found by a sequential correlation search over that same table, so no arctangent memory is needed. The focus list, the focus count and the sound speed must be held stable from the accepting edge until the result strobe.

Top module: `focal_phase_calc`

## Requirements
- R1: Focus f sits in bits [64f+63:64f] of `focusWords`, laid out as four 16-bit words. Within each focus, x is bits [17:0], y is bits [35:18] and z is bits [53:36], so y starts at bit 2 of word 1 and z starts at bit 4 of word 2. Each coordinate is an 18-bit two's-complement value.
- R2: A transducer position is taken from `posIn` when `posValid` and `posReady` are both high. z is bits [47:32], x is bits [31:16] and y is bits [15:0], each a signed 16-bit value.
- R3: The distance used for a focus is floor(sqrt(dx²+dy²+dz²)), where each difference is the focus coordinate minus the transducer coordinate.
- R4: The phase index of a focus is the low 8 bits of (distance·2^14) / soundSpeed, using integer division. When soundSpeed is 0 the quotient is all ones, so the index is 255.
- R5: The 8-bit field in bits [61:54] of focus 0 is the output intensity and is not added to any index. For each focus f ≥ 1, the same field of that focus is added modulo 256 to that focus's phase index.
- R6: Sine table entry i, for i from 0 to 255, is 128+v when i<128 and 128−v otherwise, with p = i mod 128 and v = floor(p·(128−p)·127/4096). A focus with index q adds entry q to the sine sum and entry (q+64) mod 256 to the cosine sum.
- R7: With n active foci, the averages are S = floor(floor(sineSum/n)/2) and C = floor(floor(cosineSum/n)/2). A focus count of 0 is treated as 1, and counts above 8 are treated as 8.
- R8: The output phase is the k in 0..255 that maximises (S−64)·(T[k]−128) + (C−64)·(T[(k+64) mod 256]−128), where T is the sine table. Ties go to the smallest k.
- R9: After reset `outValid`, `phaseOut` and `intensityOut` are 0 and `posReady` is 1. Once a position is accepted, `posReady` stays low until the result is out. `outValid` is high for exactly one cycle per accepted position, and `posReady` is high again in the following cycle.
- R10: Words of foci at index n or above, where n is the effective count, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| posValid | input | 1 | Transducer position offered |
| posIn | input | 48 | Packed transducer position {z, x, y} |
| focusWords | input | MAX_FOCI·64 (512) | Packed focus list, 64 bits per focus |
| numFoci | input | 4 | Number of active foci |
| soundSpeed | input | 16 | Divisor for the phase index |
| posReady | output | 1 | Block idle and able to take a position |
| outValid | output | 1 | One-cycle result strobe |
| phaseOut | output | 8 | Drive phase |
| intensityOut | output | 8 | Drive intensity |

## Verification
The bench uses negative and extreme 16-bit transducer coordinates and wide 18-bit focus coordinates. A design that sign-extends a field from the wrong bit, or swaps the x and z slices, computes a different distance and phase. A sound speed of zero must give index 255; a divider that stops early or saturates differently would return another phase. Two focus counts are probed: 0 must match 1, and 12 must match 8. A wrong clamp either divides by zero or averages over garbage foci. Changing the words of unused foci must leave the result unchanged, and this catches a loop that runs too far. Two hand-worked cases with one focus at exact quarter-turn indices pin the sine and cosine pairing: a design that reads cosine at the wrong offset, or applies the offset field to focus 0, lands on 0 instead of 64 or the reverse.

// File: rtl/focal_phase_pkg.sv
package focal_phase_pkg;

  localparam int COORD_W    = 18;
  localparam int POS_W      = 16;
  localparam int FOCUS_BITS = 64;
  localparam int FOCUS_USED = 3 * COORD_W + 8;
  localparam int PHASE_N    = 256;
  localparam int DIFF_W     = COORD_W + 1;
  localparam int PROD_W     = 2 * DIFF_W;
  localparam int SQ_W       = PROD_W + 2;
  localparam int ROOT_W     = SQ_W / 2;

  typedef struct packed {
    logic loadPos;
    logic loadFocus;
    logic sqrtStep;
    logic divInit;
    logic divStep;
    logic accum;
    logic avgLoad;
    logic searchStep;
    logic emit;
  } strobe_t;

  // Parabolic quarter-wave approximation, centred at 128.
  function automatic logic [7:0] sinEntry(input int i);
    int p;
    int v;
    p = i % 128;
    v = (p * (128 - p) * 127) / 4096;
    return (i < 128) ? 8'(128 + v) : 8'(128 - v);
  endfunction

  function automatic logic [8*PHASE_N-1:0] buildSinTable();
    logic [8*PHASE_N-1:0] t;
    t = '0;
    for (int i = 0; i < PHASE_N; i++) t[i*8 +: 8] = sinEntry(i);
    return t;
  endfunction

endpackage

// File: rtl/focal_phase_datapath.sv
module focal_phase_datapath
  import focal_phase_pkg::*;
#(
  parameter int MAX_FOCI   = 8,
  parameter int SPEED_W    = 16,
  parameter int FRAC_SHIFT = 14,
  parameter int FSEL_W     = 3,
  parameter int FC_W       = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        st,
  input  logic [FSEL_W-1:0]              focusSel,
  input  logic [7:0]                     searchK,
  input  logic [FC_W-1:0]                nEff,
  input  logic [3*POS_W-1:0]             posIn,
  input  logic [MAX_FOCI*FOCUS_BITS-1:0] focusWords,
  input  logic [SPEED_W-1:0]             soundSpeed,
  output logic                           outValid,
  output logic [7:0]                     phaseOut,
  output logic [7:0]                     intensityOut
);
  localparam int REM_W   = ROOT_W + 2;
  localparam int DIVD_W  = ROOT_W + FRAC_SHIFT;
  localparam int SUM_W   = 8 + $clog2(MAX_FOCI);
  localparam int SCORE_W = 18;
  localparam logic [8*PHASE_N-1:0] SIN_TAB = buildSinTable();

  logic signed [POS_W-1:0]   trX, trY, trZ;
  logic [FOCUS_USED-1:0]     fw;
  logic signed [COORD_W-1:0] fX, fY, fZ;
  logic [7:0]                fVal;
  logic signed [DIFF_W-1:0]  dX, dY, dZ;
  logic [PROD_W-1:0]         pX, pY, pZ;
  logic [SQ_W-1:0]           sqSum, rad;
  logic [REM_W-1:0]          rem;
  logic [ROOT_W-1:0]         root;
  logic [REM_W+1:0]          remSh, trial;
  logic                      rootBit;
  logic [DIVD_W-1:0]         quo;
  logic [SPEED_W-1:0]        dRem;
  logic [SPEED_W:0]          divSh;
  logic                      quoBit;
  logic [7:0]                phIdx, cosIdx, kCos;
  logic [SUM_W-1:0]          sinSum, cosSum, sDiv, cDiv;
  logic [7:0]                intenHold, bestK;
  logic signed [7:0]         sC, cC;
  logic signed [8:0]         tS, tC;
  logic signed [SCORE_W-1:0] score, bestScore;

  // Focus fields: x, y, z are contiguous 18-bit slices, then the 8-bit value.
  assign fw   = focusWords[{focusSel, 6'b000000} +: FOCUS_USED];
  assign fX   = fw[COORD_W-1:0];
  assign fY   = fw[2*COORD_W-1:COORD_W];
  assign fZ   = fw[3*COORD_W-1:2*COORD_W];
  assign fVal = fw[3*COORD_W +: 8];

  assign dX = DIFF_W'(fX) - DIFF_W'(trX);
  assign dY = DIFF_W'(fY) - DIFF_W'(trY);
  assign dZ = DIFF_W'(fZ) - DIFF_W'(trZ);
  assign pX = PROD_W'(dX) * PROD_W'(dX);
  assign pY = PROD_W'(dY) * PROD_W'(dY);
  assign pZ = PROD_W'(dZ) * PROD_W'(dZ);
  assign sqSum = SQ_W'(pX) + SQ_W'(pY) + SQ_W'(pZ);

  // One digit of the restoring square root per step.
  assign remSh   = {rem, rad[SQ_W-1 -: 2]};
  assign trial   = (REM_W + 2)'({root, 2'b01});
  assign rootBit = (remSh >= trial);

  // One quotient bit of the restoring divider per step.
  assign divSh  = {dRem, quo[DIVD_W-1]};
  assign quoBit = (divSh >= {1'b0, soundSpeed});

  assign phIdx  = quo[7:0] + ((focusSel == '0) ? 8'd0 : fVal);
  assign cosIdx = phIdx + 8'd64;
  assign kCos   = searchK + 8'd64;

  assign sDiv = sinSum / SUM_W'(nEff);
  assign cDiv = cosSum / SUM_W'(nEff);

  assign tS    = $signed({1'b0, SIN_TAB[{searchK, 3'b000} +: 8]}) - 9'sd128;
  assign tC    = $signed({1'b0, SIN_TAB[{kCos, 3'b000} +: 8]}) - 9'sd128;
  assign score = SCORE_W'(sC) * SCORE_W'(tS) + SCORE_W'(cC) * SCORE_W'(tC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trX <= '0; trY <= '0; trZ <= '0;
      rad <= '0; rem <= '0; root <= '0;
      quo <= '0; dRem <= '0;
      sinSum <= '0; cosSum <= '0; intenHold <= '0;
      sC <= '0; cC <= '0; bestScore <= '0; bestK <= '0;
      outValid <= 1'b0; phaseOut <= '0; intensityOut <= '0;
    end else begin
      if (st.loadPos) begin
        trZ       <= posIn[47:32];
        trX       <= posIn[31:16];
        trY       <= posIn[15:0];
        sinSum    <= '0;
        cosSum    <= '0;
        intenHold <= focusWords[3*COORD_W +: 8];
      end
      if (st.loadFocus) begin
        rad  <= sqSum;
        rem  <= '0;
        root <= '0;
      end
      if (st.sqrtStep) begin
        rem  <= rootBit ? REM_W'(remSh - trial) : REM_W'(remSh);
        root <= {root[ROOT_W-2:0], rootBit};
        rad  <= rad << 2;
      end
      if (st.divInit) begin
        quo  <= {root, {FRAC_SHIFT{1'b0}}};
        dRem <= '0;
      end
      if (st.divStep) begin
        dRem <= quoBit ? SPEED_W'(divSh - {1'b0, soundSpeed}) : SPEED_W'(divSh);
        quo  <= {quo[DIVD_W-2:0], quoBit};
      end
      if (st.accum) begin
        sinSum <= sinSum + SUM_W'(SIN_TAB[{phIdx, 3'b000} +: 8]);
        cosSum <= cosSum + SUM_W'(SIN_TAB[{cosIdx, 3'b000} +: 8]);
      end
      if (st.avgLoad) begin
        sC <= 8'(sDiv >> 1) - 8'sd64;
        cC <= 8'(cDiv >> 1) - 8'sd64;
      end
      if (st.searchStep && (searchK == 8'd0 || score > bestScore)) begin
        bestScore <= score;
        bestK     <= searchK;
      end
      outValid <= st.emit;
      if (st.emit) begin
        phaseOut     <= bestK;
        intensityOut <= intenHold;
      end
    end
  end

  // R3: the serial root is the floor square root of the squared distance
  p_sqrt_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.divInit |-> ((64'(root) * 64'(root)) <= 64'(sqSum)) &&
                   (((64'(root) + 64'd1) * (64'(root) + 64'd1)) > 64'(sqSum)));

  // R4: quotient and remainder reconstruct the scaled distance
  p_div_exact_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.accum && soundSpeed != '0) |->
      ((64'(quo) * 64'(soundSpeed) + 64'(dRem)) == (64'(root) << FRAC_SHIFT)) &&
      (dRem < soundSpeed));

  // R9: the result strobe lasts a single cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

endmodule

// File: rtl/focal_phase_ctrl.sv
module focal_phase_ctrl
  import focal_phase_pkg::*;
#(
  parameter int MAX_FOCI   = 8,
  parameter int ROOT_STEPS = 20,
  parameter int DIV_STEPS  = 34,
  parameter int FSEL_W     = 3,
  parameter int FC_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              posValid,
  input  logic [FC_W-1:0]   numFoci,
  output logic              posReady,
  output strobe_t           st,
  output logic [FSEL_W-1:0] focusSel,
  output logic [7:0]        searchK,
  output logic [FC_W-1:0]   nEff
);
  typedef enum logic [3:0] {
    S_IDLE, S_FOCUS, S_SQRT, S_DIVI, S_DIV, S_ACC, S_AVG, S_SRCH, S_EMIT
  } state_t;

  localparam logic [7:0] LAST_ROOT = 8'(ROOT_STEPS - 1);
  localparam logic [7:0] LAST_DIV  = 8'(DIV_STEPS - 1);
  localparam logic [7:0] LAST_K    = 8'(PHASE_N - 1);

  state_t     state;
  logic [7:0] cnt;
  logic       lastFocus;

  always_comb begin
    if (numFoci == '0)                       nEff = FC_W'(1);
    else if (numFoci > FC_W'(MAX_FOCI))      nEff = FC_W'(MAX_FOCI);
    else                                     nEff = numFoci;
  end

  assign lastFocus = (FC_W'(focusSel) + FC_W'(1)) == nEff;
  assign posReady  = (state == S_IDLE);
  assign searchK   = cnt;

  always_comb begin
    st = '0;
    case (state)
      S_IDLE:  st.loadPos    = posValid;
      S_FOCUS: st.loadFocus  = 1'b1;
      S_SQRT:  st.sqrtStep   = 1'b1;
      S_DIVI:  st.divInit    = 1'b1;
      S_DIV:   st.divStep    = 1'b1;
      S_ACC:   st.accum      = 1'b1;
      S_AVG:   st.avgLoad    = 1'b1;
      S_SRCH:  st.searchStep = 1'b1;
      S_EMIT:  st.emit       = 1'b1;
      default: st = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      focusSel <= '0;
    end else begin
      case (state)
        S_IDLE:  if (posValid) begin state <= S_FOCUS; focusSel <= '0; end
        S_FOCUS: begin state <= S_SQRT; cnt <= '0; end
        S_SQRT:  if (cnt == LAST_ROOT) state <= S_DIVI; else cnt <= cnt + 8'd1;
        S_DIVI:  begin state <= S_DIV; cnt <= '0; end
        S_DIV:   if (cnt == LAST_DIV) state <= S_ACC; else cnt <= cnt + 8'd1;
        S_ACC: begin
          if (lastFocus) state <= S_AVG;
          else begin focusSel <= focusSel + 1'b1; state <= S_FOCUS; end
        end
        S_AVG:   begin state <= S_SRCH; cnt <= '0; end
        S_SRCH:  if (cnt == LAST_K) state <= S_EMIT; else cnt <= cnt + 8'd1;
        S_EMIT:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: an accepted position makes the block busy on the next cycle
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (posValid && posReady) |=> !posReady);

  // R10: the focus walk never selects a focus past the effective count
  p_focus_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (FC_W'(focusSel) < nEff));

  // R7: the effective count is never zero and never above the maximum
  p_count_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (nEff != '0) && (nEff <= FC_W'(MAX_FOCI)));

endmodule

// File: rtl/focal_phase_calc.sv
module focal_phase_calc
  import focal_phase_pkg::*;
#(
  parameter int MAX_FOCI   = 8,
  parameter int SPEED_W    = 16,
  parameter int FRAC_SHIFT = 14,
  parameter int FSEL_W     = $clog2(MAX_FOCI),
  parameter int FC_W       = $clog2(MAX_FOCI) + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           posValid,
  input  logic [3*POS_W-1:0]             posIn,
  input  logic [MAX_FOCI*FOCUS_BITS-1:0] focusWords,
  input  logic [FC_W-1:0]                numFoci,
  input  logic [SPEED_W-1:0]             soundSpeed,
  output logic                           posReady,
  output logic                           outValid,
  output logic [7:0]                     phaseOut,
  output logic [7:0]                     intensityOut
);
  localparam int DIV_STEPS = ROOT_W + FRAC_SHIFT;

  strobe_t           st;
  logic [FSEL_W-1:0] focusSel;
  logic [7:0]        searchK;
  logic [FC_W-1:0]   nEff;

  focal_phase_ctrl #(
    .MAX_FOCI(MAX_FOCI), .ROOT_STEPS(ROOT_W), .DIV_STEPS(DIV_STEPS),
    .FSEL_W(FSEL_W), .FC_W(FC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .posValid(posValid), .numFoci(numFoci),
    .posReady(posReady), .st(st), .focusSel(focusSel), .searchK(searchK), .nEff(nEff)
  );

  focal_phase_datapath #(
    .MAX_FOCI(MAX_FOCI), .SPEED_W(SPEED_W), .FRAC_SHIFT(FRAC_SHIFT),
    .FSEL_W(FSEL_W), .FC_W(FC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .focusSel(focusSel), .searchK(searchK),
    .nEff(nEff), .posIn(posIn), .focusWords(focusWords), .soundSpeed(soundSpeed),
    .outValid(outValid), .phaseOut(phaseOut), .intensityOut(intensityOut)
  );

endmodule

// File: tb/focal_phase_calc_bench.sv
module focal_phase_calc_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int px; int py; int pz; int n; int ss; int seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{0, 0, 0, 1, 340, 1},
    '{1200, -300, 500, 2, 340, 2},
    '{-32768, 32767, -1, 3, 1000, 3},
    '{500, 500, 500, 4, 6400, 4},
    '{-7000, 2000, 30000, 5, 17, 5},
    '{100, -100, 0, 6, 65535, 6},
    '{32767, -32768, 32767, 7, 2048, 7},
    '{-1, -1, -1, 8, 343, 8}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         posValid = 1'b0;
  logic [47:0]  posIn = '0;
  logic [511:0] focusWords = '0;
  logic [3:0]   numFoci = 4'd1;
  logic [15:0]  soundSpeed = 16'd340;
  logic         posReady, outValid;
  logic [7:0]   phaseOut, intensityOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  focal_phase_calc u_focal_phase_calc (
    .clk(clk), .rstN(rstN), .posValid(posValid), .posIn(posIn),
    .focusWords(focusWords), .numFoci(numFoci), .soundSpeed(soundSpeed),
    .posReady(posReady), .outValid(outValid), .phaseOut(phaseOut),
    .intensityOut(intensityOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sinRef(input int i);
    int p;
    int v;
    p = i % 128;
    v = (p * (128 - p) * 127) / 4096;
    return (i < 128) ? 128 + v : 128 - v;
  endfunction

  function automatic logic [63:0] packFocus(input int x, input int y, input int z, input int v);
    logic [17:0] xb, yb, zb;
    xb = 18'(x); yb = 18'(y); zb = 18'(z);
    return {2'b00, 8'(v), zb, yb, xb};
  endfunction

  function automatic logic [511:0] makeWords(input int seed);
    logic [511:0] w;
    int s;
    s = seed * 7919 + 17;
    for (int f = 0; f < 8; f++) begin
      int x, y, z, v;
      s = s * 1103515245 + 12345; x = ((s >> 8) % 200001) - 100000;
      s = s * 1103515245 + 12345; y = ((s >> 8) % 200001) - 100000;
      s = s * 1103515245 + 12345; z = ((s >> 8) % 200001) - 100000;
      s = s * 1103515245 + 12345; v = (s >> 12) & 255;
      w[f*64 +: 64] = packFocus(x, y, z, v);
    end
    return w;
  endfunction

  function automatic logic [15:0] modelOut(input logic [47:0] pos, input logic [511:0] w,
                                           input int nIn, input int ss);
    int n, sS, cS, sA, cA, bestK;
    longint px, py, pz, best;
    n  = (nIn == 0) ? 1 : ((nIn > 8) ? 8 : nIn);
    sS = 0; cS = 0;
    pz = longint'($signed(pos[47:32]));
    px = longint'($signed(pos[31:16]));
    py = longint'($signed(pos[15:0]));
    for (int f = 0; f < n; f++) begin
      logic signed [17:0] fx, fy, fz;
      longint dx, dy, dz, d2, r, q;
      int v, idx;
      fx = w[f*64 +: 18];
      fy = w[f*64 + 18 +: 18];
      fz = w[f*64 + 36 +: 18];
      v  = int'(w[f*64 + 54 +: 8]);
      dx = longint'(fx) - px;
      dy = longint'(fy) - py;
      dz = longint'(fz) - pz;
      d2 = dx * dx + dy * dy + dz * dz;
      r = 0;
      for (int b = 19; b >= 0; b--) begin
        longint t;
        t = r | (longint'(1) << b);
        if (t * t <= d2) r = t;
      end
      if (ss == 0) q = 255;
      else q = ((r << 14) / longint'(ss)) % 256;
      idx = int'(q);
      if (f > 0) idx = (idx + v) % 256;
      sS += sinRef(idx);
      cS += sinRef((idx + 64) % 256);
    end
    sA = ((sS / n) >> 1) - 64;
    cA = ((cS / n) >> 1) - 64;
    best = 0; bestK = 0;
    for (int k = 0; k < 256; k++) begin
      longint sc;
      sc = longint'(sA) * (sinRef(k) - 128) + longint'(cA) * (sinRef((k + 64) % 256) - 128);
      if (k == 0 || sc > best) begin best = sc; bestK = k; end
    end
    return {8'(bestK), w[61:54]};
  endfunction

  task automatic runOne(input logic [47:0] p, input logic [511:0] w, input logic [3:0] n,
                        input logic [15:0] s, output logic [7:0] ph, output logic [7:0] it);
    int waitCnt;
    @(negedge clk);
    posIn = p; focusWords = w; numFoci = n; soundSpeed = s; posValid = 1'b1;
    @(negedge clk);
    posValid = 1'b0;
    chk("R9 busy after accept", int'(posReady), 0);
    waitCnt = 0;
    while (!outValid && waitCnt < 5000) begin
      @(negedge clk);
      if (!outValid) chk("R9 ready low while busy", int'(posReady), 0);
      waitCnt++;
    end
    chk("R9 result strobe seen", int'(outValid), 1);
    ph = phaseOut;
    it = intensityOut;
    @(negedge clk);
    chk("R9 strobe width one", int'(outValid), 0);
    chk("R9 ready after result", int'(posReady), 1);
  endtask

  function automatic logic [47:0] packPos(input int x, input int y, input int z);
    return {16'(z), 16'(x), 16'(y)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0]   ph, it, ph2, it2;
    logic [15:0]  exp;
    logic [511:0] wA, wB;

    repeat (3) @(negedge clk);
    chk("R9 reset outValid", int'(outValid), 0);
    chk("R9 reset posReady", int'(posReady), 1);
    chk("R9 reset phaseOut", int'(phaseOut), 0);
    chk("R9 reset intensityOut", int'(intensityOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 through the reference model
    for (int i = 0; i < 8; i++) begin
      logic [47:0] pp;
      logic [511:0] ww;
      pp = packPos(VECS[i].px, VECS[i].py, VECS[i].pz);
      ww = makeWords(VECS[i].seed);
      exp = modelOut(pp, ww, VECS[i].n, VECS[i].ss);
      runOne(pp, ww, 4'(VECS[i].n), 16'(VECS[i].ss), ph, it);
      chk($sformatf("R1 R2 R3 R4 R6 R8 vector %0d phase", i), int'(ph), int'(exp[15:8]));
      chk($sformatf("R5 vector %0d intensity", i), int'(it), int'(exp[7:0]));
    end

    // R4 R6 R8: one focus at distance 100, index 0 -> phase 0
    wA = '0;
    wA[63:0] = packFocus(0, 0, 0, 8'hA5);
    wA[127:64] = packFocus(5, 5, 5, 8'h40);
    runOne(packPos(0, 0, 100), wA, 4'd1, 16'd6400, ph, it);
    chk("R4 R8 hand index 0 phase", int'(ph), 0);
    chk("R5 hand intensity", int'(it), 8'hA5);

    // R4 R6 R8: same focus, index 64 -> phase 64
    runOne(packPos(0, 0, 100), wA, 4'd1, 16'd25600, ph, it);
    chk("R6 R8 hand index 64 phase", int'(ph), 64);

    // R4: zero sound speed gives index 255
    wB = makeWords(30);
    exp = modelOut(packPos(10, 20, 30), wB, 3, 0);
    runOne(packPos(10, 20, 30), wB, 4'd3, 16'd0, ph, it);
    chk("R4 zero speed phase", int'(ph), int'(exp[15:8]));

    // R7: count 0 behaves like 1
    wB = makeWords(40);
    runOne(packPos(-500, 700, 900), wB, 4'd0, 16'd340, ph, it);
    runOne(packPos(-500, 700, 900), wB, 4'd1, 16'd340, ph2, it2);
    chk("R7 count zero equals one", int'(ph), int'(ph2));
    exp = modelOut(packPos(-500, 700, 900), wB, 1, 340);
    chk("R7 count one phase", int'(ph2), int'(exp[15:8]));

    // R7: count above 8 behaves like 8
    wB = makeWords(50);
    runOne(packPos(3000, -3000, 100), wB, 4'd12, 16'd500, ph, it);
    runOne(packPos(3000, -3000, 100), wB, 4'd8, 16'd500, ph2, it2);
    chk("R7 count twelve equals eight", int'(ph), int'(ph2));
    exp = modelOut(packPos(3000, -3000, 100), wB, 8, 500);
    chk("R7 count eight phase", int'(ph2), int'(exp[15:8]));

    // R10: unused foci words do not matter
    wA = makeWords(60);
    wB = makeWords(61);
    wB[127:0] = wA[127:0];
    runOne(packPos(-1234, 4321, -999), wA, 4'd2, 16'd700, ph, it);
    runOne(packPos(-1234, 4321, -999), wB, 4'd2, 16'd700, ph2, it2);
    chk("R10 unused foci ignored", int'(ph2), int'(ph));
    exp = modelOut(packPos(-1234, 4321, -999), wA, 2, 700);
    chk("R10 two foci phase", int'(ph), int'(exp[15:8]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule